// File: doc/BRIEF.md
# Stop/Halt Low-Power Mode Controller

This block decides which clock domains keep running after the CPU issues a STOP or WAIT instruction. It takes a configuration bit that can turn STOP into a halt state, one-cycle STOP and WAIT request pulses from the CPU, and a wake-up event standing for an enabled interrupt. It drives separate enables for the oscillator, the internal clock, the CPU clock, the timer clock and the watchdog clock, and it reports its current mode.

The configuration bit guards the watchdog. When the bit is set, STOP does not shut the chip down. It enters HALT, a wait-like state in which only the CPU clock is gated. Software therefore cannot switch the watchdog off by executing STOP. The bit is captured once, at the first clock edge after reset is released, and later changes on the pin are ignored. An asserted reset returns the block to RUN at once.

The state machine has four states: RUN, WAIT, HALT and STOP. It has these named transitions:
- ENTER_WAIT: RUN to WAIT on a WAIT request.
- ENTER_HALT: RUN to HALT on a STOP request when the bit is set.
- ENTER_STOP: RUN to STOP on a STOP request when the bit is clear.
- WAKE: WAIT, HALT or STOP back to RUN on a wake event.
- HOLD: any other case keeps the current state.

Top module: `lpm_ctrl`

## Requirements
- R1: While reset is asserted, and in RUN, mode_o is 0 and all five clock enables are 1.
- R2: The conversion bit is taken from cfg_stop_to_halt_i at the first rising clock edge after rst_n goes high. Changes on that pin after this edge do not affect any later STOP request.
- R3: With the captured bit at 1, a STOP request in RUN moves the block to HALT (mode_o = 2) at that clock edge. In HALT only cpu_clk_en_o is 0.
- R4: With the captured bit at 0, a STOP request in RUN moves the block to STOP (mode_o = 3) at that clock edge. In STOP all five enables are 0.
- R5: wdog_clk_en_o is 0 only in STOP. When the captured bit is 1 it is never 0.
- R6: A WAIT request in RUN moves the block to WAIT (mode_o = 1) whatever the bit holds. In WAIT only cpu_clk_en_o is 0.
- R7: wake_i sampled high in WAIT, HALT or STOP returns the block to RUN at that edge, and all enables are 1 in the following cycle.
- R8: In WAIT, HALT or STOP without wake_i, STOP and WAIT requests are ignored and the mode holds.
- R9: A STOP request and a WAIT request in the same RUN cycle are treated as a STOP request.
- R10: In RUN, a request that arrives together with wake_i is discarded and the block stays in RUN.
- R11: mode_o encodes RUN = 0, WAIT = 1, HALT = 2, STOP = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_stop_to_halt_i | input | 1 | Configuration bit: 1 turns STOP into HALT |
| stop_req_i | input | 1 | STOP instruction request pulse |
| wait_req_i | input | 1 | WAIT instruction request pulse |
| wake_i | input | 1 | Enabled interrupt (wake-up event) |
| osc_en_o | output | 1 | Oscillator enable |
| int_clk_en_o | output | 1 | Internal clock enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| tmr_clk_en_o | output | 1 | Timer clock enable |
| wdog_clk_en_o | output | 1 | Watchdog clock enable |
| mode_o | output | 2 | Current mode (R11 encoding) |

## Verification
Every request and wake event is sampled at one rising edge. The new mode and the enables decoded from it are due just after that same edge, with no further register in the path. The bench drives inputs on the falling edge and advances its reference model at the rising edge. It compares mode and enables at the next falling edge, half a cycle after the result becomes valid. Capture of the conversion bit is checked by changing the pin after the capture edge and observing the mode that a later STOP reaches.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_WAIT = 2'd1,
        MODE_HALT = 2'd2,
        MODE_STOP = 2'd3
    } lpm_mode_e;

    localparam int NUM_DOMAINS = 5;

    // domain bit positions in the enable vector
    localparam int DOM_OSC  = 4;
    localparam int DOM_INT  = 3;
    localparam int DOM_CPU  = 2;
    localparam int DOM_TMR  = 1;
    localparam int DOM_WDOG = 0;

    // domains that stay clocked in WAIT and HALT: everything but the CPU
    localparam logic [NUM_DOMAINS-1:0] LIGHT_SLEEP_KEEP =
        ~(NUM_DOMAINS'(1) << DOM_CPU);

endpackage

// File: rtl/lpm_cfg_capture.sv
module lpm_cfg_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_i,
    output logic cfg_eff_o
);

    logic armed_q;
    logic cfg_q;

    // armed_q marks that the single post-reset capture has happened
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= 1'b0;
        end else if (!armed_q) begin
            cfg_q <= cfg_i;
        end
    end

    // before the capture edge the pin itself is the effective value
    always_comb begin
        cfg_eff_o = armed_q ? cfg_q : cfg_i;
    end

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_halt_i,
    input  logic      stop_req_i,
    input  logic      wait_req_i,
    input  logic      wake_i,
    output lpm_mode_e mode_o
);

    lpm_mode_e state_q;
    lpm_mode_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: ENTER_WAIT, ENTER_HALT, ENTER_STOP, WAKE, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_RUN: begin
                if (wake_i) begin
                    state_d = MODE_RUN;
                end else if (stop_req_i) begin
                    state_d = cfg_halt_i ? MODE_HALT : MODE_STOP;
                end else if (wait_req_i) begin
                    state_d = MODE_WAIT;
                end
            end
            MODE_WAIT, MODE_HALT, MODE_STOP: begin
                if (wake_i) begin
                    state_d = MODE_RUN;
                end
            end
        endcase
    end

    // output process
    always_comb begin
        mode_o = state_q;
    end

endmodule

// File: rtl/lpm_clk_gate.sv
module lpm_clk_gate
    import lpm_pkg::*;
#(
    parameter int                      N_DOM     = NUM_DOMAINS,
    parameter logic [NUM_DOMAINS-1:0]  KEEP_MASK = LIGHT_SLEEP_KEEP
) (
    input  lpm_mode_e        mode_i,
    output logic [N_DOM-1:0] en_o
);

    for (genvar g = 0; g < N_DOM; g++) begin : g_dom
        always_comb begin
            unique case (mode_i)
                MODE_RUN:             en_o[g] = 1'b1;
                MODE_WAIT, MODE_HALT: en_o[g] = KEEP_MASK[g];
                MODE_STOP:            en_o[g] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_stop_to_halt_i,
    input  logic       stop_req_i,
    input  logic       wait_req_i,
    input  logic       wake_i,
    output logic       osc_en_o,
    output logic       int_clk_en_o,
    output logic       cpu_clk_en_o,
    output logic       tmr_clk_en_o,
    output logic       wdog_clk_en_o,
    output logic [1:0] mode_o
);

    logic                   cfg_eff;
    lpm_mode_e              mode;
    logic [NUM_DOMAINS-1:0] dom_en;

    lpm_cfg_capture u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_i     (cfg_stop_to_halt_i),
        .cfg_eff_o (cfg_eff)
    );

    lpm_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_halt_i (cfg_eff),
        .stop_req_i (stop_req_i),
        .wait_req_i (wait_req_i),
        .wake_i     (wake_i),
        .mode_o     (mode)
    );

    lpm_clk_gate #(
        .N_DOM     (NUM_DOMAINS),
        .KEEP_MASK (LIGHT_SLEEP_KEEP)
    ) u_gate (
        .mode_i (mode),
        .en_o   (dom_en)
    );

    always_comb begin
        osc_en_o      = dom_en[DOM_OSC];
        int_clk_en_o  = dom_en[DOM_INT];
        cpu_clk_en_o  = dom_en[DOM_CPU];
        tmr_clk_en_o  = dom_en[DOM_TMR];
        wdog_clk_en_o = dom_en[DOM_WDOG];
        mode_o        = mode;
    end

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_eff,
    input logic       stop_req_i,
    input logic       wait_req_i,
    input logic       wake_i,
    input logic       osc_en_o,
    input logic       int_clk_en_o,
    input logic       cpu_clk_en_o,
    input logic       tmr_clk_en_o,
    input logic       wdog_clk_en_o,
    input logic [1:0] mode_o
);

    logic [4:0] en;
    assign en = {osc_en_o, int_clk_en_o, cpu_clk_en_o, tmr_clk_en_o, wdog_clk_en_o};

    assert_run_all_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0) |-> (en == 5'b11111));

    assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> $stable(cfg_eff));

    assert_stop_to_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && stop_req_i && !wake_i && cfg_eff) |=> (mode_o == 2'd2));

    assert_full_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && stop_req_i && !wake_i && !cfg_eff) |=> (mode_o == 2'd3 && en == 5'b00000));

    assert_wdog_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_eff |-> wdog_clk_en_o);

    assert_wait_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && wait_req_i && !stop_req_i && !wake_i) |=> (mode_o == 2'd1));

    assert_wake_to_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'd0 && wake_i) |=> (mode_o == 2'd0));

    assert_sleep_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'd0 && !wake_i) |=> $stable(mode_o));

    assert_wake_blocks_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && wake_i) |=> (mode_o == 2'd0));

endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_eff       (cfg_eff),
    .stop_req_i    (stop_req_i),
    .wait_req_i    (wait_req_i),
    .wake_i        (wake_i),
    .osc_en_o      (osc_en_o),
    .int_clk_en_o  (int_clk_en_o),
    .cpu_clk_en_o  (cpu_clk_en_o),
    .tmr_clk_en_o  (tmr_clk_en_o),
    .wdog_clk_en_o (wdog_clk_en_o),
    .mode_o        (mode_o)
);

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg = 1'b0;
    logic       stop_req = 1'b0;
    logic       wait_req = 1'b0;
    logic       wake = 1'b0;
    logic       osc_en, int_en, cpu_en, tmr_en, wdog_en;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;
    int exp_mode = 0;
    bit exp_cfg = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpm_ctrl u_lpm_ctrl (
        .clk                (clk),
        .rst_n              (rst_n),
        .cfg_stop_to_halt_i (cfg),
        .stop_req_i         (stop_req),
        .wait_req_i         (wait_req),
        .wake_i             (wake),
        .osc_en_o           (osc_en),
        .int_clk_en_o       (int_en),
        .cpu_clk_en_o       (cpu_en),
        .tmr_clk_en_o       (tmr_en),
        .wdog_clk_en_o      (wdog_en),
        .mode_o             (mode)
    );

    // R11 encoding: 0 RUN, 1 WAIT, 2 HALT, 3 STOP
    function automatic int model_next(int m, bit c, bit s, bit w, bit k);
        if (m == 0) begin
            if (k) return 0;                  // R10
            if (s) return c ? 2 : 3;          // R3 R4 R9
            if (w) return 1;                  // R6
            return 0;
        end
        if (k) return 0;                      // R7
        return m;                             // R8
    endfunction

    // {osc, int, cpu, tmr, wdog}
    function automatic logic [4:0] model_en(int m);
        case (m)
            0:       return 5'b11111;
            1, 2:    return 5'b11011;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic string tag_of(int m, bit s, bit w, bit k);
        if (m != 0) return k ? "R7" : "R8";
        if (k && (s || w)) return "R10";
        if (s && w) return "R9";
        if (s) return exp_cfg ? "R3" : "R4";
        if (w) return "R6";
        return "R1";
    endfunction

    task automatic check_out(string tag);
        logic [4:0] got_en;
        got_en = {osc_en, int_en, cpu_en, tmr_en, wdog_en};
        checks++;
        if (int'(mode) != exp_mode || got_en != model_en(exp_mode)) begin
            errors++;
            $display("FAIL %s: mode=%0d en=%b expected mode=%0d en=%b",
                     tag, mode, got_en, exp_mode, model_en(exp_mode));
        end
        checks++;
        if (exp_cfg && wdog_en !== 1'b1) begin
            errors++;
            $display("FAIL R5: wdog_en=%b expected 1", wdog_en);
        end
    endtask

    // drive at falling edge, model at rising edge, check at next falling edge
    task automatic step(bit s, bit w, bit k);
        string t;
        stop_req = s;
        wait_req = w;
        wake     = k;
        t = tag_of(exp_mode, s, w, k);
        @(posedge clk);
        exp_mode = model_next(exp_mode, exp_cfg, s, w, k);
        @(negedge clk);
        check_out(t);
    endtask

    task automatic do_reset(bit c);
        cfg = c;
        stop_req = 0; wait_req = 0; wake = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        exp_mode = 0;
        check_out("R1");
        rst_n = 1;
        exp_cfg = c;
        step(0, 0, 0);                       // capture edge (R2)
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);

        // conversion bit clear: full stop, then wake
        do_reset(1'b0);
        step(1, 0, 0);                       // R4
        step(0, 1, 0);                       // R8 ignored
        step(1, 0, 0);                       // R8 ignored
        step(0, 0, 1);                       // R7
        step(0, 1, 0);                       // R6
        step(0, 0, 1);                       // R7
        step(1, 1, 0);                       // R9
        step(0, 0, 1);
        step(1, 0, 1);                       // R10
        step(0, 1, 1);                       // R10

        // conversion bit set, then pin flipped after capture (R2)
        do_reset(1'b1);
        cfg = 1'b0;
        step(1, 0, 0);                       // R3 and R2: still HALT
        step(0, 0, 1);
        step(0, 1, 0);                       // R6 with bit set
        step(1, 0, 0);                       // R8
        step(0, 0, 1);

        // bit clear, pin raised after capture (R2)
        do_reset(1'b0);
        cfg = 1'b1;
        step(1, 0, 0);                       // R2: STOP, not HALT
        step(0, 0, 1);

        // random phases under both configurations
        for (int p = 0; p < 4; p++) begin
            do_reset(p[0]);
            for (int i = 0; i < 400; i++) begin
                cfg = 1'($urandom_range(0, 1));
                step(($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                     ($urandom_range(0, 4) == 0));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule